// File: doc/BRIEF.md
# Dual-Mode Electric-Field Update Cell

This block computes the next value of one electric-field component at one grid point of a finite-difference time-domain solver. It uses signed 16-bit fixed-point arithmetic. The caller presents the two stored split parts of the old field, four per-cell coefficients, the four neighbouring magnetic-flux samples and a source term. One clock edge later the registered new value appears, together with its two split parts.

Two flag bits per cell pick the behaviour. `absorb` chooses between the ordinary leapfrog update and the split-field update used inside an absorbing boundary layer. `open_cell` marks a cell as vacuum or material (1) or as a perfect conductor (0). A conductor cell stores zero. The `en` input gates every register write, so a whole array of such cells can be paused.

Top module: `fdtd_ecell`

## Requirements
- R1: While `rst_n` is low, `e_tot`, `e_px` and `e_py` are all cleared to zero.
- R2: With `en`=1, `open_cell`=1 and `absorb`=0, `e_tot` takes sat(rnd(c1a·(old_x+old_y)) + rnd(c2a·((by_hi−by_lo)−(bx_hi−bx_lo))) + src). Coefficients are signed Q1.14. rnd(p) is (p + 2^13) shifted arithmetically right by 14 bits, which rounds half upward.
- R3: In that normal-update case, `e_px` is loaded with the same value as `e_tot` and `e_py` is loaded with zero.
- R4: With `en`=1, `open_cell`=1 and `absorb`=1, `e_px` takes sat(rnd(c1a·old_x) + rnd(c2a·(by_hi−by_lo))) and `e_py` takes sat(rnd(c1b·old_y) − rnd(c2b·(bx_hi−bx_lo))). `src` is not used in this mode.
- R5: In the absorbing case, `e_tot` takes sat(new e_px + new e_py).
- R6: sat() clamps each result to the range −32768..32767. The intermediate sums are wide enough that they never wrap before the clamp.
- R7: With `en`=1 and `open_cell`=0, all three outputs are loaded with zero, whatever the other inputs are.
- R8: With `en`=0, all three outputs keep their values.
- R9: The new value is visible on the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Register write enable |
| absorb | input | 1 | 0 = normal update, 1 = split-field absorbing update |
| open_cell | input | 1 | 0 = conductor (store zero), 1 = vacuum or material |
| old_x | input | DW | Old split part x (signed) |
| old_y | input | DW | Old split part y (signed) |
| c1a | input | DW | Decay coefficient, normal mode and x part (Q1.14) |
| c2a | input | DW | Curl coefficient, normal mode and x part (Q1.14) |
| c1b | input | DW | Decay coefficient, y part (Q1.14) |
| c2b | input | DW | Curl coefficient, y part (Q1.14) |
| by_hi | input | DW | Flux y at the +x neighbour |
| by_lo | input | DW | Flux y at the −x neighbour |
| bx_hi | input | DW | Flux x at the +y neighbour |
| bx_lo | input | DW | Flux x at the −y neighbour |
| src | input | DW | Injected source term (normal mode) |
| e_tot | output | DW | Registered new total field |
| e_px | output | DW | Registered new split part x |
| e_py | output | DW | Registered new split part y |

## Verification
The bench builds the cell with its default parameters: a 16-bit word and 14 fraction bits. At that width the flux differences are 17 bits and the curl is 18 bits, so operands at full scale reach both clamp limits in each mode. The bench drives such operands on purpose. It also applies a few thousand random vectors in which coefficients up to ±1 meet random field values. This covers the rounding of negative products and the switching of cells between normal, absorbing and conductor behaviour from one cycle to the next.

// File: rtl/fdtd_ecell.sv
module fdtd_ecell #(
  parameter int DW = 16,
  parameter int FB = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 absorb,
  input  logic                 open_cell,
  input  logic signed [DW-1:0] old_x,
  input  logic signed [DW-1:0] old_y,
  input  logic signed [DW-1:0] c1a,
  input  logic signed [DW-1:0] c2a,
  input  logic signed [DW-1:0] c1b,
  input  logic signed [DW-1:0] c2b,
  input  logic signed [DW-1:0] by_hi,
  input  logic signed [DW-1:0] by_lo,
  input  logic signed [DW-1:0] bx_hi,
  input  logic signed [DW-1:0] bx_lo,
  input  logic signed [DW-1:0] src,
  output logic signed [DW-1:0] e_tot,
  output logic signed [DW-1:0] e_px,
  output logic signed [DW-1:0] e_py
);
  localparam int SW = 2*DW + 4;
  localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (FB-1));
  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(64'sd1);

  function automatic logic signed [SW-1:0] rnd(input logic signed [SW-1:0] p);
    return (p + HALF) >>> FB;
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > MAXV) return DW'(MAXV);
    if (v < MINV) return DW'(MINV);
    return DW'(v);
  endfunction

  logic signed [SW-1:0] dby, dbx, curl, oldsum;
  logic signed [DW-1:0] n_tot, p_x, p_y, p_tot;
  logic signed [DW-1:0] nx_tot, nx_x, nx_y;

  assign dby    = SW'(by_hi) - SW'(by_lo);
  assign dbx    = SW'(bx_hi) - SW'(bx_lo);
  assign curl   = dby - dbx;
  assign oldsum = SW'(old_x) + SW'(old_y);

  assign n_tot = sat(rnd(SW'(c1a) * oldsum) + rnd(SW'(c2a) * curl) + SW'(src));
  assign p_x   = sat(rnd(SW'(c1a) * SW'(old_x)) + rnd(SW'(c2a) * dby));
  assign p_y   = sat(rnd(SW'(c1b) * SW'(old_y)) - rnd(SW'(c2b) * dbx));
  assign p_tot = sat(SW'(p_x) + SW'(p_y));

  always_comb begin
    if (!open_cell) begin
      nx_tot = '0; nx_x = '0; nx_y = '0;
    end else if (absorb) begin
      nx_tot = p_tot; nx_x = p_x; nx_y = p_y;
    end else begin
      nx_tot = n_tot; nx_x = n_tot; nx_y = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_tot <= '0;
      e_px  <= '0;
      e_py  <= '0;
    end else if (en) begin
      e_tot <= nx_tot;
      e_px  <= nx_x;
      e_py  <= nx_y;
    end
  end

  a_r7_conductor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !open_cell) |=> (e_tot == '0 && e_px == '0 && e_py == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(e_tot) && $stable(e_px) && $stable(e_py)));

  a_r3_normal_parts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && open_cell && !absorb) |=> (e_py == '0 && e_px == e_tot));

  a_r4_zero_coeff_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    (en && open_cell && absorb && c1a == '0 && c2a == '0 && c1b == '0 && c2b == '0)
      |=> (e_px == '0 && e_py == '0 && e_tot == '0));
endmodule

// File: tb/sim_fdtd_ecell.sv
module sim_fdtd_ecell;
  localparam int CLK_NS = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, absorb = 1'b0, open_cell = 1'b1;
  logic signed [DW-1:0] old_x = '0, old_y = '0, c1a = '0, c2a = '0, c1b = '0, c2b = '0;
  logic signed [DW-1:0] by_hi = '0, by_lo = '0, bx_hi = '0, bx_lo = '0, src = '0;
  logic signed [DW-1:0] e_tot, e_px, e_py;

  int total = 0;
  int bad = 0;
  longint xt = 0, xx = 0, xy = 0;

  always #(CLK_NS/2) clk = ~clk;

  fdtd_ecell #(.DW(DW), .FB(14)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .absorb(absorb), .open_cell(open_cell),
    .old_x(old_x), .old_y(old_y), .c1a(c1a), .c2a(c2a), .c1b(c1b), .c2b(c2b),
    .by_hi(by_hi), .by_lo(by_lo), .bx_hi(bx_hi), .bx_lo(bx_lo), .src(src),
    .e_tot(e_tot), .e_px(e_px), .e_py(e_py));

  function automatic longint rnd(longint p);
    return (p + 64'sd8192) >>> 14;
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model();
    longint dby, dbx, a, b;
    dby = longint'(by_hi) - longint'(by_lo);
    dbx = longint'(bx_hi) - longint'(bx_lo);
    if (!en) return;
    if (!open_cell) begin
      xt = 0; xx = 0; xy = 0;
    end else if (absorb) begin
      a = sat(rnd(longint'(c1a) * longint'(old_x)) + rnd(longint'(c2a) * dby));
      b = sat(rnd(longint'(c1b) * longint'(old_y)) - rnd(longint'(c2b) * dbx));
      xx = a; xy = b; xt = sat(a + b);
    end else begin
      xt = sat(rnd(longint'(c1a) * (longint'(old_x) + longint'(old_y)))
               + rnd(longint'(c2a) * (dby - dbx)) + longint'(src));
      xx = xt; xy = 0;
    end
  endtask

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req);
    model();
    @(posedge clk);
    #1;
    chk({req, " tot"}, longint'(e_tot), xt);
    chk({req, " px"},  longint'(e_px),  xx);
    chk({req, " py"},  longint'(e_py),  xy);
  endtask

  task automatic put(logic e, logic ab, logic oc,
                     int ox, int oy, int k1a, int k2a, int k1b, int k2b,
                     int yh, int yl, int xh, int xl, int s);
    @(negedge clk);
    en = e; absorb = ab; open_cell = oc;
    old_x = DW'(ox); old_y = DW'(oy); c1a = DW'(k1a); c2a = DW'(k2a);
    c1b = DW'(k1b); c2b = DW'(k2b);
    by_hi = DW'(yh); by_lo = DW'(yl); bx_hi = DW'(xh); bx_lo = DW'(xl); src = DW'(s);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    put(1, 0, 1, 1000, 2000, 16384, 16384, 16384, 16384, 5, 1, 2, 3, 7);
    @(posedge clk); #1;
    chk("R1 tot", longint'(e_tot), 0);
    chk("R1 px", longint'(e_px), 0);
    chk("R1 py", longint'(e_py), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R9: normal update, one edge of latency
    put(1, 0, 1, 1000, 200, 8192, 4096, 0, 0, 300, 100, 50, 20, 11);
    step("R2 R3 R9 normal");
    // R2: rounding of a negative product
    put(1, 0, 1, -3, 0, 8192, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 round negative");
    // R6: positive clamp in normal mode
    put(1, 0, 1, 32767, 32767, 16383, 16383, 0, 0, 32767, -32768, -32768, 32767, 32767);
    step("R6 normal clamp high");
    // R6: negative clamp in normal mode
    put(1, 0, 1, -32768, -32768, 16383, 16383, 0, 0, -32768, 32767, 32767, -32768, -32768);
    step("R6 normal clamp low");
    // R4 R5: absorbing split update
    put(1, 1, 1, 1200, -700, 15000, 9000, 12000, 7000, 400, -100, 90, 300, 999);
    step("R4 R5 absorb");
    // R6: absorbing part and total clamp
    put(1, 1, 1, 32767, 32767, 16383, 16383, 16383, 16383, 32767, -32768, -32768, 32767, 0);
    step("R6 absorb clamp");
    // R7: conductor cell clears outputs
    put(1, 1, 0, 500, 500, 9000, 9000, 9000, 9000, 100, 0, 0, 100, 100);
    step("R7 conductor");
    put(1, 0, 1, 700, 10, 16000, 3000, 0, 0, 40, 10, 5, 1, 2);
    step("R2 refill");
    // R8: enable low keeps state despite new inputs
    put(0, 1, 0, -9999, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);
    step("R8 hold");
    put(0, 0, 1, 32767, 32767, 16383, 16383, 0, 0, 32767, -32768, 0, 0, 32767);
    step("R8 hold again");

    for (int i = 0; i < 3000; i++) begin
      logic e, ab, oc;
      e  = ($urandom_range(0, 7) != 0);
      ab = 1'($urandom_range(0, 1));
      oc = ($urandom_range(0, 5) != 0);
      put(e, ab, oc,
          int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
          int'($urandom_range(0, 32767)) - 16384, int'($urandom_range(0, 32767)) - 16384,
          int'($urandom_range(0, 32767)) - 16384, int'($urandom_range(0, 32767)) - 16384,
          int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
          int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
          int'($urandom_range(0, 65535)) - 32768);
      step("R2 R4 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule